// File: doc/BRIEF.md
# Indirect Jump Landing-Pad Guard

This block watches the in-order stream of retiring instructions of a RISC-V style core. It enforces control-flow integrity on register-indirect jumps. After an indirect jump that is not exempt, the next retired instruction must be a landing-pad hint. That hint must sit on a 4-byte boundary. Its optional 20-bit label must match the label the caller placed in register x7. When any of these conditions is broken, the block raises a software-check exception one cycle later, with a fixed cause and trap value.

Each retirement is one beat on a valid/ready stream that carries the PC, the instruction word and the current value of x7. The guard never applies back-pressure: `ret_ready` is held high, so a beat is consumed in every cycle that `ret_valid` is high. Idle cycles between beats are allowed and leave the tracking state untouched.

A small control port sets a per-task enable bit and a sticky lock bit. The core pulses `trap_enter` when it takes any trap, which abandons a pending landing-pad expectation.

Top module: `lpad_guard`

## Requirements
- R1: After reset, `cfg_en`, `cfg_lock` and `exc_valid` are 0, `exc_cause` and `exc_tval` are 0, and no landing pad is expected.
- R2: A retired 32-bit jump-and-link-register (opcode bits [6:0]=1100111, funct3 bits [14:12]=000, source register in bits [19:15]) arms the guard. So does a compressed jump-register form (bits [1:0]=10, bits [15:13]=100, bits [6:2]=0, source register in bits [11:7] nonzero). In both cases the source register must not be x1, x5 or x7; jumps through those three never arm the guard.
- R3: While armed, a retired instruction that is not a landing pad is a violation. A landing pad has opcode bits [6:0]=0010111 and destination bits [11:7]=0.
- R4: While armed, a landing pad whose PC has bits [1:0] nonzero is a violation.
- R5: The landing-pad label is bits [31:12] of the instruction. A zero label skips the comparison. A nonzero label that differs from bits [31:12] of x7 is a violation.
- R6: A violation is reported in the cycle after the offending beat. `exc_valid` is high for exactly one cycle, with `exc_cause`=18 and `exc_tval`=2, whichever condition occurred. In every other cycle all three outputs are 0.
- R7: While `cfg_en` is 0, nothing arms and nothing is reported, and any pending expectation is dropped.
- R8: A control write (`cfg_we`=1) loads `cfg_en` from `cfg_en_wr` unless `cfg_lock` is already 1. The same write ORs `cfg_lock_wr` into `cfg_lock`. The lock stays set until reset.
- R9: The expectation ends with the first beat retired after arming, whether that beat passes or fails. A correct landing pad reports nothing and does not re-arm.
- R10: `trap_enter` clears the expectation. It takes priority over an arming jump retired in the same cycle.
- R11: `ret_ready` is always 1. Cycles with `ret_valid`=0 neither check nor disarm.
- R12: A control write takes effect in the following cycle. A beat retired in the same cycle as the write is judged with the previous enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | Retirement beat valid |
| ret_ready | output | 1 | Always 1; the guard never stalls retirement |
| ret_pc | input | 32 | PC of the retiring instruction |
| ret_insn | input | 32 | Instruction word (upper half zero for compressed) |
| ret_x7 | input | 32 | Value of x7 as seen by this instruction |
| trap_enter | input | 1 | Core is entering a trap handler |
| cfg_we | input | 1 | Control write strobe |
| cfg_en_wr | input | 1 | Enable value to write |
| cfg_lock_wr | input | 1 | Lock request to write |
| cfg_en | output | 1 | Current enable |
| cfg_lock | output | 1 | Current lock |
| exc_valid | output | 1 | Software-check exception pulse |
| exc_cause | output | 6 | Exception cause (18 when valid) |
| exc_tval | output | 32 | Trap value (2 when valid) |

## Verification
Two functions can collide in one cycle. The first pair is a control write and a retirement: the bench retires the checked beat in the same cycle as a write that clears the enable, and expects the violation to be reported under the old enable. The second pair is a trap and an arming jump: the bench pulses `trap_enter` alongside the jump and then retires a non-pad, expecting silence. The bench's behavioural model applies the old-state-first ordering of R10 and R12 independently, and the design's outputs are compared against it in every cycle.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
  localparam int LABEL_W = 20;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;

  typedef struct packed {
    logic               ijump;   // register-indirect jump
    logic               exempt;  // source is x1, x5 or x7
    logic               pad;     // landing-pad hint
    logic [LABEL_W-1:0] label;   // pad label field
  } dec_t;

  function automatic logic src_exempt(input logic [4:0] rs);
    return (rs == 5'd1) || (rs == 5'd5) || (rs == 5'd7);
  endfunction
endpackage

// File: rtl/lpad_decode.sv
module lpad_decode
  import lpad_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter bit RVC_EN = 1'b1
) (
  input  logic [XLEN-1:0] insn_i,
  output dec_t            dec_o
);
  localparam int LBL_LO = XLEN - LABEL_W;

  logic       j32;
  logic       jc;
  logic [4:0] rs_c;

  assign j32 = (insn_i[6:0] == OPC_JALR) && (insn_i[14:12] == 3'b000);

  generate
    if (RVC_EN) begin : g_rvc
      assign rs_c = insn_i[11:7];
      assign jc   = (insn_i[1:0] == 2'b10) && (insn_i[15:13] == 3'b100) &&
                    (insn_i[6:2] == 5'd0) && (rs_c != 5'd0);
    end else begin : g_norvc
      assign rs_c = 5'd0;
      assign jc   = 1'b0;
    end
  endgenerate

  always_comb begin
    dec_o        = '0;
    dec_o.ijump  = j32 | jc;
    dec_o.exempt = j32 ? src_exempt(insn_i[19:15]) : (jc & src_exempt(rs_c));
    dec_o.pad    = (insn_i[6:0] == OPC_AUIPC) && (insn_i[11:7] == 5'd0);
    dec_o.label  = insn_i[XLEN-1:LBL_LO];
  end

  always_comb begin
    a_r2_kinds_exclusive: assert (!(j32 && jc));
  end
endmodule

// File: rtl/lpad_cfg.sv
module lpad_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  logic en_wr_i,
  input  logic lock_wr_i,
  output logic en_o,
  output logic lock_o
);
  logic en_q, lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
    end else if (we_i) begin
      if (!lock_q) en_q <= en_wr_i;
      lock_q <= lock_q | lock_wr_i;
    end
  end

  assign en_o   = en_q;
  assign lock_o = lock_q;

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  a_r8_locked_enable_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(en_q));
  a_r12_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(en_q) && $stable(lock_q));
endmodule

// File: rtl/lpad_track.sv
module lpad_track
  import lpad_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 6,
  parameter int CAUSE_CODE = 18,
  parameter int TVAL_CODE  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire_i,
  input  logic               en_i,
  input  logic               trap_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    x7_i,
  input  dec_t               dec_i,
  output logic               exc_valid_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic [XLEN-1:0]    exc_tval_o
);
  localparam int LBL_LO = XLEN - LABEL_W;
  localparam logic [CAUSE_W-1:0] CAUSE_V = CAUSE_W'(CAUSE_CODE);
  localparam logic [XLEN-1:0]    TVAL_V  = XLEN'(TVAL_CODE);

  logic armed_q, armed_d;
  logic no_pad, misaligned, bad_label, viol;

  assign no_pad     = !dec_i.pad;
  assign misaligned = pc_i[1:0] != 2'b00;
  assign bad_label  = (dec_i.label != '0) && (dec_i.label != x7_i[XLEN-1:LBL_LO]);
  assign viol       = fire_i && en_i && armed_q && (no_pad || misaligned || bad_label);

  always_comb begin
    armed_d = armed_q;
    if (trap_i || !en_i)  armed_d = 1'b0;
    else if (fire_i)      armed_d = armed_q ? 1'b0 : (dec_i.ijump && !dec_i.exempt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      exc_valid_o <= 1'b0;
      exc_cause_o <= '0;
      exc_tval_o  <= '0;
    end else begin
      armed_q     <= armed_d;
      exc_valid_o <= viol;
      exc_cause_o <= viol ? CAUSE_V : '0;
      exc_tval_o  <= viol ? TVAL_V : '0;
    end
  end

  a_r3_report_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_o |-> $past(armed_q) && $past(fire_i) && $past(en_i));
  a_r6_codes: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_o |-> (exc_cause_o == CAUSE_V) && (exc_tval_o == TVAL_V));
  a_r6_quiet_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid_o |-> (exc_cause_o == '0) && (exc_tval_o == '0));
  a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !exc_valid_o && !armed_q);
  a_r9_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i && armed_q |=> !armed_q);
  a_r10_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> !armed_q);
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i && !trap_i && en_i |=> $stable(armed_q));
endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
  import lpad_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 6,
  parameter int CAUSE_CODE = 18,
  parameter int TVAL_CODE  = 2,
  parameter bit RVC_EN     = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ret_valid,
  output logic               ret_ready,
  input  logic [XLEN-1:0]    ret_pc,
  input  logic [XLEN-1:0]    ret_insn,
  input  logic [XLEN-1:0]    ret_x7,
  input  logic               trap_enter,
  input  logic               cfg_we,
  input  logic               cfg_en_wr,
  input  logic               cfg_lock_wr,
  output logic               cfg_en,
  output logic               cfg_lock,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_tval
);
  dec_t dec;
  logic fire;

  assign ret_ready = 1'b1;
  assign fire      = ret_valid & ret_ready;

  lpad_decode #(.XLEN(XLEN), .RVC_EN(RVC_EN)) u_dec (
    .insn_i (ret_insn),
    .dec_o  (dec)
  );

  lpad_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (cfg_we),
    .en_wr_i   (cfg_en_wr),
    .lock_wr_i (cfg_lock_wr),
    .en_o      (cfg_en),
    .lock_o    (cfg_lock)
  );

  lpad_track #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .CAUSE_CODE(CAUSE_CODE), .TVAL_CODE(TVAL_CODE)
  ) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_i      (fire),
    .en_i        (cfg_en),
    .trap_i      (trap_enter),
    .pc_i        (ret_pc),
    .x7_i        (ret_x7),
    .dec_i       (dec),
    .exc_valid_o (exc_valid),
    .exc_cause_o (exc_cause),
    .exc_tval_o  (exc_tval)
  );

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid);
endmodule

// File: tb/sim_lpad_guard.sv
module sim_lpad_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid = 1'b0;
  logic        ret_ready;
  logic [31:0] ret_pc = '0, ret_insn = '0, ret_x7 = '0;
  logic        trap_enter = 1'b0;
  logic        cfg_we = 1'b0, cfg_en_wr = 1'b0, cfg_lock_wr = 1'b0;
  logic        cfg_en, cfg_lock, exc_valid;
  logic [5:0]  exc_cause;
  logic [31:0] exc_tval;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  lpad_guard u0 (.*);

  // behavioural reference
  bit m_en, m_lock, m_armed, m_v;
  int m_cause, m_tval;

  function automatic bit is_jump(input logic [31:0] w, output int rs);
    rs = 0;
    if (w[6:0] == 7'h67 && w[14:12] == 0) begin rs = int'(w[19:15]); return 1; end
    if (w[1:0] == 2'b10 && w[15:13] == 3'b100 && w[6:2] == 0 && w[11:7] != 0) begin
      rs = int'(w[11:7]); return 1;
    end
    return 0;
  endfunction

  function automatic bit bad_target(input logic [31:0] pc, w, x7);
    if (w[6:0] != 7'h17 || w[11:7] != 0) return 1;
    if (pc % 4 != 0) return 1;
    if (w[31:12] != 0 && w[31:12] != x7[31:12]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_lock = 0; m_armed = 0; m_v = 0; m_cause = 0; m_tval = 0;
    end else begin
      int rs;
      bit jmp;
      bit nv;
      nv = ret_valid && m_en && m_armed && bad_target(ret_pc, ret_insn, ret_x7);
      jmp = is_jump(ret_insn, rs);
      if (trap_enter || !m_en) m_armed = 0;
      else if (ret_valid) m_armed = m_armed ? 0 : (jmp && !(rs == 1 || rs == 5 || rs == 7));
      m_v = nv; m_cause = nv ? 18 : 0; m_tval = nv ? 2 : 0;
      if (cfg_we) begin
        if (!m_lock) m_en = cfg_en_wr;
        m_lock = m_lock | cfg_lock_wr;
      end
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("ready", ret_ready, 1);
    chk("exc_valid", exc_valid, m_v);
    chk("exc_cause", exc_cause, m_cause);
    chk("exc_tval", exc_tval, m_tval);
    chk("cfg_en", cfg_en, m_en);
    chk("cfg_lock", cfg_lock, m_lock);
  end

  // drivers, called at a negative edge
  task automatic beat(input logic [31:0] pc, w, x7 = 32'h0);
    ret_valid = 1; ret_pc = pc; ret_insn = w; ret_x7 = x7;
    @(negedge clk);
    ret_valid = 0; ret_insn = 32'h13;
  endtask
  task automatic idle(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic wr(input logic e, l);
    cfg_we = 1; cfg_en_wr = e; cfg_lock_wr = l;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [31:0] jalr(input int rs);
    return (32'(rs) << 15) | 32'h0000_00E7;
  endfunction
  function automatic logic [31:0] pad(input logic [19:0] lbl);
    return {lbl, 12'h017};
  endfunction
  localparam logic [31:0] NOP = 32'h0000_0013;

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; idle(2);
    chk("R1 exc_valid", exc_valid, 0);
    cur_req = "R7"; beat(32'h100, jalr(10)); beat(32'h200, NOP); idle(2);
    cur_req = "R8"; wr(1, 0); idle();
    chk("R8 cfg_en", cfg_en, 1);
    cur_req = "R3"; beat(32'h100, jalr(10)); beat(32'h200, NOP); idle(2);
    cur_req = "R3"; beat(32'h100, jalr(12)); beat(32'h200, 32'h0000_0097); idle(2);
    cur_req = "R9"; beat(32'h100, jalr(11)); beat(32'h200, pad(0)); beat(32'h204, NOP); idle(2);
    cur_req = "R2"; beat(32'h100, jalr(1)); beat(32'h200, NOP);
    beat(32'h100, jalr(5)); beat(32'h200, NOP);
    beat(32'h100, jalr(7)); beat(32'h200, NOP); idle(2);
    cur_req = "R4"; beat(32'h100, jalr(6)); beat(32'h202, pad(0)); idle(2);
    cur_req = "R5"; beat(32'h100, jalr(6)); beat(32'h200, pad(20'hABCDE), 32'hABCD_E123); idle();
    beat(32'h100, jalr(6)); beat(32'h200, pad(20'hABCDF), 32'hABCD_E000); idle();
    beat(32'h100, jalr(6)); beat(32'h200, pad(0), 32'h1234_5000); idle(2);
    cur_req = "R2"; beat(32'h100, 32'h0000_8502); beat(32'h102, NOP); idle();
    beat(32'h100, 32'h0000_9282); beat(32'h102, NOP); idle();
    beat(32'h100, 32'h0000_9582); beat(32'h104, pad(0)); beat(32'h108, NOP); idle();
    beat(32'h100, 32'h0000_8382); beat(32'h102, NOP); idle(2);
    cur_req = "R11"; beat(32'h100, jalr(10)); idle(3); beat(32'h200, NOP); idle(2);
    cur_req = "R10";
    trap_enter = 1; beat(32'h100, jalr(10)); trap_enter = 0; beat(32'h200, NOP); idle();
    beat(32'h100, jalr(10)); trap_enter = 1; idle(); trap_enter = 0; beat(32'h200, NOP); idle(2);
    cur_req = "R7"; beat(32'h100, jalr(10)); wr(0, 0); wr(1, 0); beat(32'h200, NOP); idle(2);
    cur_req = "R12"; beat(32'h100, jalr(10));
    cfg_we = 1; cfg_en_wr = 0; cfg_lock_wr = 0; beat(32'h200, NOP); cfg_we = 0;
    chk("R12 exc_valid", exc_valid, 1);
    idle(); chk("R12 cfg_en", cfg_en, 0);
    cur_req = "R8"; wr(1, 1); idle(); wr(0, 0); idle();
    chk("R8 locked cfg_en", cfg_en, 1);
    wr(0, 1); idle();
    chk("R8 lock", cfg_lock, 1);
    cur_req = "R6"; beat(32'h100, jalr(3)); beat(32'h201, 32'h0000_0033);
    chk("R6 cause", exc_cause, 18); chk("R6 tval", exc_tval, 2);
    idle(); chk("R6 pulse end", exc_valid, 0);
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule